// File: doc/BRIEF.md
# Self-Restoring Destructive-Read Byte Store

This block is a single-port store of byte-wide words. An address decoder turns the incoming address into a one-hot word select. Each stored bit behaves like a set/reset latch whose inputs are active high. Because of this, writes and reads both touch the word more than once.

- **Write:** the selected word is first wiped to zero, and then its bits are set from the latched write data.
- **Read:** the word is moved onto an internal transfer bus, which empties the cell. The value is then captured in a holding register and presented on the read port. In a final step, an internal sequencer writes the value back into the same word.

Callers therefore see an ordinary memory. They raise a read or write strobe while the busy flag is low, and wait for busy to fall. For a read, they take the byte when the one-cycle read-valid pulse appears.

Top module: `dr_byte_mem`

## Requirements
- R1: While reset is held and on the first cycle after it, busy, rd_valid and rd_data are all 0.
- R2: After reset, a read of any address returns 0x00.
- R3: A write strobe sampled while busy is low is accepted at that clock edge. Busy is then high for exactly the two following cycles (clear, then set), and later reads of that address return the written byte.
- R4: A write replaces the whole word: bits set by an earlier write and clear in the new data read back as 0.
- R5: A read strobe sampled while busy is low is accepted at that edge, and busy is then high for exactly three cycles. rd_valid is high only in the third of those cycles, for one cycle, with rd_data equal to the stored byte.
- R6: A read leaves the stored value intact through the internal write-back, so repeated reads of one address return the same byte.
- R7: rd_data changes only in the cycle when rd_valid is high, and otherwise holds the last byte read, including across writes.
- R8: Read or write strobes sampled while busy is high are ignored: they change neither the memory contents nor the busy length of the operation in flight.
- R9: If both strobes are sampled together while busy is low, the write is performed and the read is dropped (no rd_valid pulse follows).
- R10: Each of the 2^ADDR_W addresses selects exactly one word, and a write to one address leaves every other address unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Write strobe, sampled when busy is low |
| rd_en | input | 1 | Read strobe, sampled when busy is low |
| addr | input | ADDR_W | Word address |
| wr_data | input | DATA_W | Byte to store |
| busy | output | 1 | High while a read or write sequence is in progress |
| rd_valid | output | 1 | One-cycle pulse marking a fresh rd_data |
| rd_data | output | DATA_W | Last byte read, held between reads |

## Verification
The assertions rest on two assumptions. First, strobes only start a sequence when busy is low. Second, there is at least one idle cycle between sequences, so busy never stays high for more than three cycles in a row and the word select is never more than one-hot.

The stimulus drives strobes at the falling edge. It deliberately drives strobes while busy is high and both strobes at once, because the block must tolerate both cases. The bench model treats those strobes as ignored, or resolves them in favour of the write. Contents are always observed through ordinary reads, since the cleared interval inside a read is hidden by the write-back.

// File: rtl/drm_pkg.sv
package drm_pkg;

  typedef enum logic [2:0] {
    ST_IDLE  = 3'd0,
    ST_WCLR  = 3'd1,
    ST_WSET  = 3'd2,
    ST_RXFER = 3'd3,
    ST_RCAP  = 3'd4,
    ST_RRST  = 3'd5
  } drm_state_e;

endpackage

// File: rtl/drm_decoder.sv
module drm_decoder #(
  parameter int ADDR_W = 8,
  parameter int DEPTH  = 1 << ADDR_W
) (
  input  logic              en,
  input  logic [ADDR_W-1:0] addr,
  output logic [DEPTH-1:0]  sel
);

  // one comparator per word; at most one output can be high
  for (genvar i = 0; i < DEPTH; i++) begin : g_sel
    localparam logic [ADDR_W-1:0] IDX = ADDR_W'(i);
    assign sel[i] = en && (addr == IDX);
  end

endmodule

// File: rtl/drm_array.sv
module drm_array #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 256
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [DEPTH-1:0]  sel,
  input  logic              clr_en,
  input  logic              set_en,
  input  logic              drive_en,
  input  logic [DATA_W-1:0] set_data,
  output logic [DATA_W-1:0] xfer_bus
);

  logic [DATA_W-1:0] words [DEPTH];
  logic [DATA_W-1:0] or_tree;

  // each word is a row of set/reset cells: reset wipes the row, set ORs bits in
  for (genvar i = 0; i < DEPTH; i++) begin : g_word
    logic do_clr;
    logic do_set;
    assign do_clr = sel[i] && clr_en;
    assign do_set = sel[i] && set_en;

    always_ff @(posedge clk) begin
      if (rst) begin
        words[i] <= '0;
      end else if (do_clr) begin
        words[i] <= '0;
      end else if (do_set) begin
        words[i] <= words[i] | set_data;
      end
    end
  end

  // wired-OR read bus across all selected rows
  always_comb begin
    or_tree = '0;
    for (int i = 0; i < DEPTH; i++) begin
      if (sel[i]) begin
        or_tree = or_tree | words[i];
      end
    end
  end

  assign xfer_bus = drive_en ? or_tree : '0;

endmodule

// File: rtl/drm_ctrl.sv
module drm_ctrl
  import drm_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  input  logic [DATA_W-1:0] xfer_bus,
  output logic [ADDR_W-1:0] addr_q,
  output logic              sel_en,
  output logic              clr_en,
  output logic              set_en,
  output logic              drive_en,
  output logic [DATA_W-1:0] set_data,
  output logic              busy,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  drm_state_e        state;
  logic [DATA_W-1:0] hold_q;
  logic [DATA_W-1:0] rd_data_q;
  logic              rd_valid_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      addr_q     <= '0;
      hold_q     <= '0;
      rd_data_q  <= '0;
      rd_valid_q <= 1'b0;
    end else begin
      rd_valid_q <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (wr_en) begin
            state  <= ST_WCLR;
            addr_q <= addr;
            hold_q <= wr_data;
          end else if (rd_en) begin
            state  <= ST_RXFER;
            addr_q <= addr;
          end
        end
        ST_WCLR:  state <= ST_WSET;
        ST_WSET:  state <= ST_IDLE;
        ST_RXFER: begin
          hold_q <= xfer_bus;
          state  <= ST_RCAP;
        end
        ST_RCAP: begin
          rd_data_q  <= hold_q;
          rd_valid_q <= 1'b1;
          state      <= ST_RRST;
        end
        ST_RRST:  state <= ST_IDLE;
        default:  state <= ST_IDLE;
      endcase
    end
  end

  assign sel_en   = (state != ST_IDLE);
  assign clr_en   = (state == ST_WCLR) || (state == ST_RXFER);
  assign set_en   = (state == ST_WSET) || (state == ST_RRST);
  assign drive_en = (state == ST_RXFER);
  assign set_data = hold_q;
  assign busy     = (state != ST_IDLE);
  assign rd_valid = rd_valid_q;
  assign rd_data  = rd_data_q;

endmodule

// File: rtl/dr_byte_mem.sv
module dr_byte_mem #(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wr_data,
  output logic              busy,
  output logic              rd_valid,
  output logic [DATA_W-1:0] rd_data
);

  localparam int DEPTH = 1 << ADDR_W;

  logic [ADDR_W-1:0] addr_q;
  logic              sel_en;
  logic              clr_en;
  logic              set_en;
  logic              drive_en;
  logic [DATA_W-1:0] set_data;
  logic [DATA_W-1:0] xfer_bus;
  logic [DEPTH-1:0]  word_sel;

  drm_ctrl #(
    .ADDR_W(ADDR_W),
    .DATA_W(DATA_W)
  ) i_ctrl (
    .clk      (clk),
    .rst      (rst),
    .wr_en    (wr_en),
    .rd_en    (rd_en),
    .addr     (addr),
    .wr_data  (wr_data),
    .xfer_bus (xfer_bus),
    .addr_q   (addr_q),
    .sel_en   (sel_en),
    .clr_en   (clr_en),
    .set_en   (set_en),
    .drive_en (drive_en),
    .set_data (set_data),
    .busy     (busy),
    .rd_valid (rd_valid),
    .rd_data  (rd_data)
  );

  drm_decoder #(
    .ADDR_W(ADDR_W),
    .DEPTH (DEPTH)
  ) i_dec (
    .en   (sel_en),
    .addr (addr_q),
    .sel  (word_sel)
  );

  drm_array #(
    .DATA_W(DATA_W),
    .DEPTH (DEPTH)
  ) i_array (
    .clk      (clk),
    .rst      (rst),
    .sel      (word_sel),
    .clr_en   (clr_en),
    .set_en   (set_en),
    .drive_en (drive_en),
    .set_data (set_data),
    .xfer_bus (xfer_bus)
  );

endmodule

// File: rtl/drm_checker.sv
module drm_checker #(
  parameter int DATA_W = 8,
  parameter int DEPTH  = 256
) (
  input logic              clk,
  input logic              rst,
  input logic              wr_en,
  input logic              rd_en,
  input logic              busy,
  input logic              rd_valid,
  input logic [DATA_W-1:0] rd_data,
  input logic [DEPTH-1:0]  word_sel
);

  p_accept_r3: assert property (@(posedge clk) disable iff (rst)
    (!busy && (wr_en || rd_en)) |=> busy);

  p_rvalid_single_r5: assert property (@(posedge clk) disable iff (rst)
    rd_valid |=> !rd_valid);

  p_rvalid_in_busy_r5: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> busy);

  p_rdata_hold_r7: assert property (@(posedge clk) disable iff (rst)
    !rd_valid |-> $stable(rd_data));

  p_busy_max_r8: assert property (@(posedge clk) disable iff (rst)
    (busy && $past(busy) && $past(busy, 2)) |=> !busy);

  p_sel_onehot_r10: assert property (@(posedge clk) disable iff (rst)
    $onehot0(word_sel));

endmodule

bind dr_byte_mem drm_checker #(
  .DATA_W(DATA_W),
  .DEPTH (DEPTH)
) i_chk (
  .clk      (clk),
  .rst      (rst),
  .wr_en    (wr_en),
  .rd_en    (rd_en),
  .busy     (busy),
  .rd_valid (rd_valid),
  .rd_data  (rd_data),
  .word_sel (word_sel)
);

// File: tb/test_dr_byte_mem.sv
`timescale 1ns/1ps
module test_dr_byte_mem;

  localparam int AW = 8;
  localparam int DW = 8;
  localparam int NW = 1 << AW;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          wr_en = 1'b0;
  logic          rd_en = 1'b0;
  logic [AW-1:0] addr = '0;
  logic [DW-1:0] wr_data = '0;
  logic          busy;
  logic          rd_valid;
  logic [DW-1:0] rd_data;

  always #2 clk = ~clk;

  dr_byte_mem #(.ADDR_W(AW), .DATA_W(DW)) i_dr_byte_mem (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wr_data(wr_data), .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data)
  );

  int    n_cmp = 0;
  int    n_bad = 0;
  bit    done  = 1'b0;
  string tag   = "R1";

  // behavioural reference
  int m_mem [NW];
  int m_left = 0;
  bit m_is_rd = 1'b0;
  int m_val = 0;
  bit e_busy = 1'b0;
  bit e_rv = 1'b0;
  int e_rd = 0;

  task automatic cmp(input string t, input int act, input int exp);
    n_cmp++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h at %0t", t, act, exp, $time);
    end
  endtask

  // check outputs from the last edge, drive inputs, advance model for the next edge
  task automatic cyc(input bit we, input bit re, input int a, input int d);
    @(negedge clk);
    cmp({tag, " busy"}, int'(busy), int'(e_busy));
    cmp({tag, " rd_valid"}, int'(rd_valid), int'(e_rv));
    cmp({tag, " rd_data"}, int'(rd_data), e_rd);
    wr_en = we; rd_en = re; addr = AW'(a); wr_data = DW'(d);
    e_rv = 1'b0;
    if (m_left == 0) begin
      if (we) begin
        m_left = 2; m_is_rd = 1'b0; m_mem[a] = d;
      end else if (re) begin
        m_left = 3; m_is_rd = 1'b1; m_val = m_mem[a];
      end
    end else begin
      m_left--;
      if (m_is_rd && m_left == 1) begin
        e_rv = 1'b1; e_rd = m_val;
      end
    end
    e_busy = (m_left != 0);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) cyc(1'b0, 1'b0, 0, 0);
  endtask

  task automatic do_wr(input int a, input int d);
    cyc(1'b1, 1'b0, a, d);
    idle(2);
  endtask

  task automatic do_rd(input int a);
    cyc(1'b0, 1'b1, a, 0);
    idle(3);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < NW; i++) m_mem[i] = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    tag = "R1";
    cmp("R1 busy in reset", int'(busy), 0);
    cmp("R1 rd_valid in reset", int'(rd_valid), 0);
    cmp("R1 rd_data in reset", int'(rd_data), 0);
    rst = 1'b0;
    idle(2);

    tag = "R2";
    do_rd(0); do_rd(1); do_rd(127); do_rd(NW - 1);

    tag = "R3";
    do_wr(5, 8'hA5);
    do_rd(5);
    cmp("R3 read back", int'(rd_data), 8'hA5);

    tag = "R4";
    do_wr(9, 8'hF0);
    do_wr(9, 8'h0F);
    do_rd(9);
    cmp("R4 whole word replaced", int'(rd_data), 8'h0F);

    tag = "R5";
    do_wr(200, 8'h3C);
    cyc(1'b0, 1'b1, 200, 0);
    idle(3);

    tag = "R6";
    do_rd(9); do_rd(9); do_rd(9);
    cmp("R6 repeated read", int'(rd_data), 8'h0F);

    tag = "R7";
    do_rd(200);
    do_wr(201, 8'h77);
    idle(4);
    cmp("R7 rd_data held", int'(rd_data), 8'h3C);

    tag = "R8";
    cyc(1'b1, 1'b0, 30, 8'h11);
    cyc(1'b1, 1'b0, 31, 8'hEE);
    cyc(1'b0, 1'b1, 30, 0);
    idle(1);
    cyc(1'b0, 1'b1, 40, 0);
    cyc(1'b1, 1'b0, 41, 8'h99);
    cyc(1'b0, 1'b1, 42, 0);
    idle(1);
    do_rd(31);
    cmp("R8 ignored write", int'(rd_data), 0);
    do_rd(41);
    cmp("R8 ignored write in read", int'(rd_data), 0);

    tag = "R9";
    cyc(1'b1, 1'b1, 50, 8'h5A);
    idle(4);
    do_rd(50);
    cmp("R9 write wins", int'(rd_data), 8'h5A);

    tag = "R10";
    for (int i = 0; i < NW; i++) do_wr(i, (i * 37 + 5) & 8'hFF);
    for (int i = 0; i < NW; i++) begin
      do_rd(i);
      cmp("R10 per-address value", int'(rd_data), (i * 37 + 5) & 8'hFF);
    end

    idle(2);
    done = 1'b1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule